// File: doc/BRIEF.md
# Warp Branch Divergence and Reconvergence Stack

This block is the per-warp control for divergent branches in a SIMD group of `LANES` lanes (32 by default). Each lane owns one bit of the active mask. When a branch retires, the block compares the per-lane branch outcomes of the active lanes. If all active lanes agree, only the program counter moves. If they disagree, the lanes are split into a taken set and a not-taken set. The block then saves two records on a LIFO of (PC, mask, reconvergence PC) records. The lower record restores the merged mask at the join point. The upper record holds the not-taken path, which is still pending.

The taken path runs first, with only its own lanes enabled. When the next PC of the running path equals the reconvergence PC of the current context, the top record is popped. The first pop starts the not-taken path under its own mask. The second pop returns the warp to the join point with the original mask. Nesting works the same way, one level deeper per divergence. If a divergence would need more than `DEPTH` records, a sticky error flag is raised instead.

The fetch side presents each retiring instruction's PC and branch fields on `step_i`. It uses `next_pc_o` and `mask_o` to choose and enable the next instruction.

Top module: `warp_reconv_stack`

## Requirements
- R1: After a synchronous reset, `next_pc_o` is `RESET_PC` (0), `mask_o` is all ones and `ovf_o` is 0, whatever state the block held before the reset.
- R2: A non-branch step gives `next_pc_o = pc_i + 1` with the mask unchanged, unless R5 or R6 applies. A cycle without `step_i` leaves all outputs unchanged. With an empty stack, no PC value changes the mask.
- R3: A branch on which every active lane agrees pushes nothing and keeps the mask. The next PC is `tgt_i` if any active lane has its bit set in `taken_i`, and `fall_i` otherwise. Bits of `taken_i` for inactive lanes are ignored.
- R4: A branch on which the active lanes disagree gives `next_pc_o = tgt_i` and `mask_o = active & taken_i`. It pushes a join record and a pending not-taken record.
- R5: When a path's next PC equals the current reconvergence PC and the top record is the pending not-taken path, the next PC becomes that branch's `fall_i` and the mask becomes `active & ~taken_i` of the diverging branch.
- R6: When the last pending path reaches the reconvergence PC, the next PC is that PC and the mask is the full mask held before the divergence.
- R7: Divergences nest, and their records unwind in last-in, first-out order.
- R8: A divergent branch whose `tgt_i` equals `rpc_i` pushes only the join record. In the same step it starts the not-taken path: `next_pc_o = fall_i` and `mask_o = active & ~taken_i`.
- R9: A uniform branch whose destination equals the current reconvergence PC also pops in that same step.
- R10: A divergent branch that finds fewer than two free records sets `ovf_o`. That branch leaves the stack and the mask unchanged and gives `next_pc_o = tgt_i`. `ovf_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | An instruction of the warp retires this cycle |
| pc_i | input | PC_W | PC of the retiring instruction |
| br_i | input | 1 | The retiring instruction is a conditional branch |
| taken_i | input | LANES | Per-lane branch outcome, 1 = taken |
| tgt_i | input | PC_W | Branch target PC |
| rpc_i | input | PC_W | Join (reconvergence) PC of the branch |
| fall_i | input | PC_W | Fall-through PC of the branch |
| next_pc_o | output | PC_W | Registered PC of the next instruction |
| mask_o | output | LANES | Registered active-lane mask |
| ovf_o | output | 1 | Sticky stack-overflow error |

## Verification
Two functions of this block can coincide in one step: a branch decision and a reconvergence pop. The first case is a uniform branch whose destination is the live join PC. The bench drives it from the not-taken side of an inner divergence and expects the outer join record's mask at once. The second case is a divergent branch whose target equals its own join PC. Here a push and the start of the not-taken path fall in the same step, and the bench expects a one-record push: the fall-through PC, the not-taken mask, and a later single pop back to the pre-branch mask. Both cases are judged on the registered outputs one edge after the step.

// File: rtl/reconv_pkg.sv
package reconv_pkg;
  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_UNIFORM = 2'd1,
    CLS_SPLIT   = 2'd2
  } br_cls_e;
endpackage

// File: rtl/reconv_split.sv
module reconv_split
  import reconv_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             is_br,
  input  logic [LANES-1:0] act,
  input  logic [LANES-1:0] taken,
  output br_cls_e          cls,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask
);
  // inactive lanes never vote (R3)
  always_comb begin
    tk_mask = act & taken;
    nt_mask = act & ~taken;
    if (!is_br)
      cls = CLS_NONE;
    else if (tk_mask == '0 || nt_mask == '0)
      cls = CLS_UNIFORM;
    else
      cls = CLS_SPLIT;
  end
endmodule

// File: rtl/reconv_lifo.sv
module reconv_lifo #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_a,
  input  logic [PC_W-1:0]  a_pc,
  input  logic [LANES-1:0] a_mask,
  input  logic [PC_W-1:0]  a_rpc,
  input  logic             push_b,
  input  logic [PC_W-1:0]  b_pc,
  input  logic [LANES-1:0] b_mask,
  input  logic [PC_W-1:0]  b_rpc,
  input  logic             pop,
  output logic [CNT_W-1:0] cnt,
  output logic [PC_W-1:0]  top_pc,
  output logic [LANES-1:0] top_mask,
  output logic [PC_W-1:0]  top_rpc
);
  logic [PC_W-1:0]  pc_m   [DEPTH];
  logic [LANES-1:0] mask_m [DEPTH];
  logic [PC_W-1:0]  rpc_m  [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;

  assign cnt = cnt_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_a && cnt_q == CNT_W'(i)) begin
        pc_m[i]   <= a_pc;
        mask_m[i] <= a_mask;
        rpc_m[i]  <= a_rpc;
      end
      if (push_b && (cnt_q + CNT_W'(1)) == CNT_W'(i)) begin
        pc_m[i]   <= b_pc;
        mask_m[i] <= b_mask;
        rpc_m[i]  <= b_rpc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (push_a)
      cnt_q <= cnt_q + (push_b ? CNT_W'(2) : CNT_W'(1));
    else if (pop)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  always_comb begin
    top_idx  = (cnt_q == '0) ? '0 : IDX_W'(cnt_q - CNT_W'(1));
    top_pc   = pc_m[top_idx];
    top_mask = mask_m[top_idx];
    top_rpc  = rpc_m[top_idx];
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  p_no_empty_pop_r2: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt_q != '0);
  p_room_for_pair_r10: assert property (@(posedge clk) disable iff (rst)
    push_b |-> (push_a && cnt_q <= CNT_W'(DEPTH - 2)));
endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
  import reconv_pkg::*;
#(
  parameter int          LANES    = 32,
  parameter int          PC_W     = 32,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             br_i,
  input  logic [LANES-1:0] taken_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  logic [PC_W-1:0]  rpc_i,
  input  logic [PC_W-1:0]  fall_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [LANES-1:0] mask_o,
  output logic             ovf_o
);
  logic [PC_W-1:0]  pc_q, rpc_q, n_pc, n_rpc, cand;
  logic [LANES-1:0] mask_q, n_mask, tk_mask, nt_mask;
  logic             ovf_q, n_ovf;
  logic             push_a, push_b, pop, room;
  br_cls_e          cls;
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  top_pc, top_rpc;
  logic [LANES-1:0] top_mask;

  reconv_split #(.LANES(LANES)) u_split (
    .is_br(br_i), .act(mask_q), .taken(taken_i),
    .cls(cls), .tk_mask(tk_mask), .nt_mask(nt_mask)
  );

  // record a: join point; record b: pending not-taken path
  reconv_lifo #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst(rst),
    .push_a(push_a), .a_pc(rpc_i), .a_mask(mask_q), .a_rpc(rpc_q),
    .push_b(push_b), .b_pc(fall_i), .b_mask(nt_mask), .b_rpc(rpc_i),
    .pop(pop), .cnt(cnt),
    .top_pc(top_pc), .top_mask(top_mask), .top_rpc(top_rpc)
  );

  assign room = (cnt <= CNT_W'(DEPTH - 2));

  always_comb begin
    push_a = 1'b0;
    push_b = 1'b0;
    pop    = 1'b0;
    n_pc   = pc_q;
    n_mask = mask_q;
    n_rpc  = rpc_q;
    n_ovf  = ovf_q;
    cand   = pc_i + PC_W'(1);
    if (step_i) begin
      if (cls == CLS_SPLIT) begin
        if (!room) begin
          n_ovf = 1'b1;          // R10: refuse the split
          n_pc  = tgt_i;
        end else if (tgt_i == rpc_i) begin
          push_a = 1'b1;         // R8: empty taken path
          n_pc   = fall_i;
          n_mask = nt_mask;
          n_rpc  = rpc_i;
        end else begin
          push_a = 1'b1;         // R4
          push_b = 1'b1;
          n_pc   = tgt_i;
          n_mask = tk_mask;
          n_rpc  = rpc_i;
        end
      end else begin
        if (cls == CLS_UNIFORM)
          cand = (tk_mask != '0) ? tgt_i : fall_i;
        if (cnt != '0 && cand == rpc_q) begin
          pop    = 1'b1;         // R5, R6, R9
          n_pc   = top_pc;
          n_mask = top_mask;
          n_rpc  = top_rpc;
        end else begin
          n_pc = cand;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= PC_W'(RESET_PC);
      mask_q <= '1;
      rpc_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pc_q   <= n_pc;
      mask_q <= n_mask;
      rpc_q  <= n_rpc;
      ovf_q  <= n_ovf;
    end
  end

  assign next_pc_o = pc_q;
  assign mask_o    = mask_q;
  assign ovf_o     = ovf_q;

  p_mask_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    mask_o != '0);
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ($stable(next_pc_o) && $stable(mask_o)));
  p_push_narrows_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt > $past(cnt)) |-> ((mask_o & ~$past(mask_o)) == '0));
endmodule

// File: tb/warp_reconv_stack_test.sv
`timescale 1ns/1ps
module warp_reconv_stack_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_i, br_i;
  logic [31:0] pc_i, taken_i, tgt_i, rpc_i, fall_i;
  logic [31:0] next_pc_o, mask_o;
  logic        ovf_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  warp_reconv_stack uut (
    .clk(clk), .rst(rst), .step_i(step_i), .pc_i(pc_i), .br_i(br_i),
    .taken_i(taken_i), .tgt_i(tgt_i), .rpc_i(rpc_i), .fall_i(fall_i),
    .next_pc_o(next_pc_o), .mask_o(mask_o), .ovf_o(ovf_o)
  );

  typedef struct packed {
    logic        step;
    logic        br;
    logic [31:0] pc;
    logic [31:0] taken;
    logic [31:0] tgt;
    logic [31:0] rpc;
    logic [31:0] fall;
    logic [31:0] epc;
    logic [31:0] emask;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{1'b1,1'b0,32'h10,32'h0,32'h0,32'h0,32'h0,32'h11,32'hFFFFFFFF,8'd2},              // R2 sequential
    '{1'b0,1'b0,32'h0,32'h0,32'h0,32'h0,32'h0,32'h11,32'hFFFFFFFF,8'd2},               // R2 idle hold
    '{1'b1,1'b1,32'h11,32'hFFFFFFFF,32'h40,32'h50,32'h12,32'h40,32'hFFFFFFFF,8'd3},    // R3 all taken
    '{1'b1,1'b1,32'h40,32'h0,32'h80,32'h50,32'h41,32'h41,32'hFFFFFFFF,8'd3},           // R3 none taken
    '{1'b1,1'b1,32'h41,32'h0000FFFF,32'h60,32'h70,32'h42,32'h60,32'h0000FFFF,8'd4},    // R4 split
    '{1'b1,1'b0,32'h60,32'h0,32'h0,32'h0,32'h0,32'h61,32'h0000FFFF,8'd2},
    '{1'b1,1'b1,32'h61,32'hFFFF0000,32'h99,32'h9A,32'h62,32'h62,32'h0000FFFF,8'd3},    // R3 inactive bits ignored
    '{1'b1,1'b1,32'h62,32'h000000FF,32'h68,32'h6A,32'h63,32'h68,32'h000000FF,8'd7},    // R7 nested split
    '{1'b1,1'b0,32'h68,32'h0,32'h0,32'h0,32'h0,32'h69,32'h000000FF,8'd2},
    '{1'b1,1'b0,32'h69,32'h0,32'h0,32'h0,32'h0,32'h63,32'h0000FF00,8'd5},              // R5 inner else
    '{1'b1,1'b1,32'h63,32'h0000FF00,32'h6A,32'h77,32'h64,32'h6A,32'h0000FFFF,8'd9},    // R9 branch+pop
    '{1'b1,1'b0,32'h6F,32'h0,32'h0,32'h0,32'h0,32'h42,32'hFFFF0000,8'd5},              // R5 outer else
    '{1'b1,1'b0,32'h42,32'h0,32'h0,32'h0,32'h0,32'h43,32'hFFFF0000,8'd2},
    '{1'b1,1'b1,32'h43,32'h0FFF0000,32'h48,32'h48,32'h44,32'h44,32'hF0000000,8'd8},    // R8 tgt==rpc
    '{1'b1,1'b0,32'h47,32'h0,32'h0,32'h0,32'h0,32'h48,32'hFFFF0000,8'd6},              // R6 inner join
    '{1'b1,1'b0,32'h6F,32'h0,32'h0,32'h0,32'h0,32'h70,32'hFFFFFFFF,8'd6},              // R6 outer join
    '{1'b1,1'b0,32'h6F,32'h0,32'h0,32'h0,32'h0,32'h70,32'hFFFFFFFF,8'd2}               // R2 empty stack
  };

  task automatic chk(input int req, input logic [31:0] epc, input logic [31:0] emask,
                     input logic eovf);
    checks++;
    if (next_pc_o !== epc || mask_o !== emask || ovf_o !== eovf) begin
      failures++;
      $display("FAIL R%0d: pc=%h exp %h mask=%h exp %h ovf=%b exp %b",
               req, next_pc_o, epc, mask_o, emask, ovf_o, eovf);
    end
  endtask

  task automatic drive(input logic st, input logic b, input logic [31:0] p,
                       input logic [31:0] tk, input logic [31:0] tg,
                       input logic [31:0] rp, input logic [31:0] fl);
    step_i = st; br_i = b; pc_i = p; taken_i = tk;
    tgt_i = tg; rpc_i = rp; fall_i = fl;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    step_i = 1'b0; br_i = 1'b0; pc_i = '0; taken_i = '0;
    tgt_i = '0; rpc_i = '0; fall_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(1, 32'h0, 32'hFFFFFFFF, 1'b0);          // R1 reset state

    // table walk: R2..R9
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].step, VT[i].br, VT[i].pc, VT[i].taken, VT[i].tgt,
            VT[i].rpc, VT[i].fall);
      chk(int'(VT[i].req), VT[i].epc, VT[i].emask, 1'b0);
    end

    // R10: four nested splits fill 8 records, the fifth overflows
    drive(1'b1, 1'b1, 32'h200, 32'h0000FFFF, 32'h210, 32'h1001, 32'h201);
    chk(4, 32'h210, 32'h0000FFFF, 1'b0);
    drive(1'b1, 1'b1, 32'h210, 32'h000000FF, 32'h220, 32'h1002, 32'h211);
    chk(7, 32'h220, 32'h000000FF, 1'b0);
    drive(1'b1, 1'b1, 32'h220, 32'h0000000F, 32'h230, 32'h1003, 32'h221);
    chk(7, 32'h230, 32'h0000000F, 1'b0);
    drive(1'b1, 1'b1, 32'h230, 32'h00000003, 32'h240, 32'h1004, 32'h231);
    chk(10, 32'h240, 32'h00000003, 1'b0);       // R10 exactly full, no flag
    drive(1'b1, 1'b1, 32'h240, 32'h00000001, 32'h250, 32'h1005, 32'h241);
    chk(10, 32'h250, 32'h00000003, 1'b1);       // R10 overflow
    drive(1'b1, 1'b0, 32'h250, 32'h0, 32'h0, 32'h0, 32'h0);
    chk(10, 32'h251, 32'h00000003, 1'b1);       // R10 sticky
    drive(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    chk(10, 32'h251, 32'h00000003, 1'b1);

    // R1: reset from a deep, flagged state
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(1, 32'h0, 32'hFFFFFFFF, 1'b0);
    drive(1'b1, 1'b0, 32'h1004, 32'h0, 32'h0, 32'h0, 32'h0);
    chk(1, 32'h1005, 32'hFFFFFFFF, 1'b0);       // R1 stack emptied: no pop

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule